// File: doc/BRIEF.md
# Reservation Station Pool with Oldest-First Dispatch

This block holds a small pool of waiting instructions for a single function unit in an out-of-order core. The issue stage writes an instruction into a free slot. Each slot keeps the instruction's opcode, the reorder-buffer tag of its result, and two operand slots. An operand slot holds either a value that is already known or the tag of the instruction that will produce the value.

Every slot watches the result broadcast bus. When the bus carries a tag that a pending operand is waiting for, the slot takes the data and marks that operand as ready. When one or more slots have both operands and the function unit can accept work, the pool hands the oldest of these slots to the unit and frees that slot on the same clock edge. The issue stage sees a full flag and must hold back while it is set. A flush input empties the pool when an exception is recovered.

Top module: `rs_pool`

## Requirements
- R1: After reset, no slot is occupied, `disp_valid` is 0 and `full` is 0.
- R2: On a rising edge with `issue_valid`=1, `full`=0 and `flush`=0, the instruction is written into a free slot. When `full`=1 the issued instruction is dropped and the contents of the pool do not change.
- R3: `full` is 1 exactly when all NENT slots are occupied.
- R4: A pending operand (ready bit 0) whose tag equals `cdb_tag` while `cdb_valid`=1 takes `cdb_data` and becomes ready on that edge. An operand that is already ready is never overwritten by the bus.
- R5: An issued operand with ready bit 0 whose tag matches the bus in the same cycle as the issue is captured on that edge and is not lost.
- R6: `disp_valid` is 1 only when `fu_ready`=1 and some slot is occupied with both of its operands ready. The `disp_*` fields then carry that slot's opcode, result tag and operand values.
- R7: When several slots are ready, the one issued earliest is dispatched.
- R8: A slot that is dispatched is freed on the same rising edge and is not dispatched again.
- R9: On a rising edge with `flush`=1, every slot is emptied, and an issue request made in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties every slot |
| issue_valid | input | 1 | Issue request |
| issue_op | input | OPW | Opcode |
| issue_dtag | input | TAGW | Reorder-buffer tag of the result |
| issue_a_rdy | input | 1 | Operand A value is known |
| issue_a_tag | input | TAGW | Producer tag of operand A |
| issue_a_val | input | DATAW | Value of operand A |
| issue_b_rdy | input | 1 | Operand B value is known |
| issue_b_tag | input | TAGW | Producer tag of operand B |
| issue_b_val | input | DATAW | Value of operand B |
| full | output | 1 | All slots occupied; issue must stall |
| cdb_valid | input | 1 | Result broadcast is valid |
| cdb_tag | input | TAGW | Tag of the broadcast result |
| cdb_data | input | DATAW | Broadcast result value |
| fu_ready | input | 1 | Function unit can accept work |
| disp_valid | output | 1 | An instruction is handed over in this cycle |
| disp_op | output | OPW | Opcode being dispatched |
| disp_dtag | output | TAGW | Result tag being dispatched |
| disp_a | output | DATAW | Operand A value |
| disp_b | output | DATAW | Operand B value |

## Verification
Three actions can fall on the same edge: an issue that meets a matching broadcast, and a dispatch that frees a slot while a new issue or a flush arrives. Directed sequences set these up on purpose, for example by issuing a pending operand while its tag is on the bus, or by issuing into a full pool while the unit drains it. Random cycles with a narrow tag range make them occur often. Each cycle is judged against a bench model. The model keeps its own issue sequence numbers and predicts the dispatched fields, the choice of the oldest slot and the full flag before each edge.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int NENT  = 4,
  parameter int TAGW  = 4,
  parameter int DATAW = 32,
  parameter int OPW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             issue_valid,
  input  logic [OPW-1:0]   issue_op,
  input  logic [TAGW-1:0]  issue_dtag,
  input  logic             issue_a_rdy,
  input  logic [TAGW-1:0]  issue_a_tag,
  input  logic [DATAW-1:0] issue_a_val,
  input  logic             issue_b_rdy,
  input  logic [TAGW-1:0]  issue_b_tag,
  input  logic [DATAW-1:0] issue_b_val,
  output logic             full,
  input  logic             cdb_valid,
  input  logic [TAGW-1:0]  cdb_tag,
  input  logic [DATAW-1:0] cdb_data,
  input  logic             fu_ready,
  output logic             disp_valid,
  output logic [OPW-1:0]   disp_op,
  output logic [TAGW-1:0]  disp_dtag,
  output logic [DATAW-1:0] disp_a,
  output logic [DATAW-1:0] disp_b
);
  logic [NENT-1:0]  busy, a_ok, b_ok, ready, grant, alloc;
  logic [OPW-1:0]   op_q  [NENT];
  logic [TAGW-1:0]  dt_q  [NENT];
  logic [TAGW-1:0]  at_q  [NENT];
  logic [TAGW-1:0]  bt_q  [NENT];
  logic [DATAW-1:0] av_q  [NENT];
  logic [DATAW-1:0] bv_q  [NENT];
  logic [NENT-1:0]  older [NENT];

  assign ready = busy & a_ok & b_ok;
  assign full  = &busy;

  wire do_issue = issue_valid && !full && !flush;
  wire fire     = fu_ready && |grant;
  wire a_hit    = cdb_valid && !issue_a_rdy && issue_a_tag == cdb_tag;
  wire b_hit    = cdb_valid && !issue_b_rdy && issue_b_tag == cdb_tag;

  always_comb begin
    grant = '0;
    for (int i = 0; i < NENT; i++) begin
      grant[i] = ready[i];
      for (int j = 0; j < NENT; j++)
        if (j != i && ready[j] && older[j][i]) grant[i] = 1'b0;
    end
  end

  always_comb begin
    alloc = '0;
    for (int i = NENT-1; i >= 0; i--)
      if (!busy[i]) alloc = NENT'(1) << i;
  end

  always_comb begin
    disp_op = '0; disp_dtag = '0; disp_a = '0; disp_b = '0;
    for (int i = 0; i < NENT; i++)
      if (grant[i]) begin
        disp_op   = op_q[i];
        disp_dtag = dt_q[i];
        disp_a    = av_q[i];
        disp_b    = bv_q[i];
      end
  end
  assign disp_valid = fire;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy <= '0;
      a_ok <= '0;
      b_ok <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (fire && grant[i]) busy[i] <= 1'b0;
        if (busy[i] && cdb_valid) begin
          if (!a_ok[i] && at_q[i] == cdb_tag) begin a_ok[i] <= 1'b1; av_q[i] <= cdb_data; end
          if (!b_ok[i] && bt_q[i] == cdb_tag) begin b_ok[i] <= 1'b1; bv_q[i] <= cdb_data; end
        end
        if (do_issue && alloc[i]) begin
          busy[i]  <= 1'b1;
          op_q[i]  <= issue_op;
          dt_q[i]  <= issue_dtag;
          at_q[i]  <= issue_a_tag;
          bt_q[i]  <= issue_b_tag;
          a_ok[i]  <= issue_a_rdy || a_hit;
          b_ok[i]  <= issue_b_rdy || b_hit;
          av_q[i]  <= a_hit ? cdb_data : issue_a_val;
          bv_q[i]  <= b_hit ? cdb_data : issue_b_val;
          older[i] <= '0;
          for (int j = 0; j < NENT; j++)
            if (j != i) older[j][i] <= 1'b1;
        end
      end
    end
  end

  // R7
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R6
  disp_needs_fu_chk: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |-> fu_ready);
  // R2
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush && !disp_valid) |=> full);
  // R8
  disp_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !issue_valid) |=> !full);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!full && !disp_valid));
endmodule

// File: tb/rs_pool_bench.sv
module rs_pool_bench;
  localparam int NENT = 4, TAGW = 4, DATAW = 32, OPW = 4;

  logic clk = 0, rst_n = 0, flush = 0;
  logic issue_valid = 0, issue_a_rdy = 0, issue_b_rdy = 0;
  logic [OPW-1:0] issue_op = 0;
  logic [TAGW-1:0] issue_dtag = 0, issue_a_tag = 0, issue_b_tag = 0, cdb_tag = 0;
  logic [DATAW-1:0] issue_a_val = 0, issue_b_val = 0, cdb_data = 0;
  logic cdb_valid = 0, fu_ready = 0;
  logic full, disp_valid;
  logic [OPW-1:0] disp_op;
  logic [TAGW-1:0] disp_dtag;
  logic [DATAW-1:0] disp_a, disp_b;

  always #2.5 clk = ~clk;

  rs_pool #(.NENT(NENT), .TAGW(TAGW), .DATAW(DATAW), .OPW(OPW)) u_rs_pool (.*);

  int tests = 0, fails = 0;
  bit m_busy [NENT], m_aok [NENT], m_bok [NENT];
  int m_op [NENT], m_dt [NENT], m_at [NENT], m_bt [NENT], m_seq [NENT];
  logic [DATAW-1:0] m_av [NENT], m_bv [NENT];
  int seq_ctr = 0;

  function automatic int pick_oldest();
    int best = -1;
    for (int i = 0; i < NENT; i++)
      if (m_busy[i] && m_aok[i] && m_bok[i] && (best < 0 || m_seq[i] < m_seq[best])) best = i;
    return best;
  endfunction

  function automatic bit m_full();
    for (int i = 0; i < NENT; i++) if (!m_busy[i]) return 0;
    return 1;
  endfunction

  task automatic chk(input string r, input logic [DATAW-1:0] act, input logic [DATAW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input string r);
    int s;
    bit mf;
    #1;
    s  = pick_oldest();
    mf = m_full();
    chk({r, " R3 full"}, full, mf);
    chk({r, " R6 disp_valid"}, disp_valid, (s >= 0) && fu_ready);
    if (s >= 0 && fu_ready) begin
      chk({r, " R7 disp_op"}, disp_op, m_op[s]);
      chk({r, " R7 disp_dtag"}, disp_dtag, m_dt[s]);
      chk({r, " R4 disp_a"}, disp_a, m_av[s]);
      chk({r, " R4 disp_b"}, disp_b, m_bv[s]);
    end
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < NENT; i++) m_busy[i] = 0;
    end else begin
      int fr = -1;
      for (int i = NENT-1; i >= 0; i--) if (!m_busy[i]) fr = i;
      if (s >= 0 && fu_ready) m_busy[s] = 0;
      for (int i = 0; i < NENT; i++)
        if (m_busy[i] && cdb_valid) begin
          if (!m_aok[i] && m_at[i] == cdb_tag) begin m_aok[i] = 1; m_av[i] = cdb_data; end
          if (!m_bok[i] && m_bt[i] == cdb_tag) begin m_bok[i] = 1; m_bv[i] = cdb_data; end
        end
      if (issue_valid && !mf) begin
        m_busy[fr] = 1; m_op[fr] = issue_op; m_dt[fr] = issue_dtag;
        m_at[fr] = issue_a_tag; m_bt[fr] = issue_b_tag; m_seq[fr] = seq_ctr++;
        m_aok[fr] = issue_a_rdy; m_av[fr] = issue_a_val;
        m_bok[fr] = issue_b_rdy; m_bv[fr] = issue_b_val;
        if (cdb_valid && !issue_a_rdy && issue_a_tag == cdb_tag) begin m_aok[fr] = 1; m_av[fr] = cdb_data; end
        if (cdb_valid && !issue_b_rdy && issue_b_tag == cdb_tag) begin m_bok[fr] = 1; m_bv[fr] = cdb_data; end
      end
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    issue_valid = 0; cdb_valid = 0; flush = 0;
  endtask

  task automatic put(input int op, input bit ar, input int at, input bit br, input int bt);
    issue_valid = 1; issue_op = OPW'(op); issue_dtag = TAGW'(op + 3);
    issue_a_rdy = ar; issue_a_tag = TAGW'(at); issue_a_val = DATAW'(32'hA000 + op);
    issue_b_rdy = br; issue_b_tag = TAGW'(bt); issue_b_val = DATAW'(32'hB000 + op);
  endtask

  initial begin
    #20000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    for (int i = 0; i < NENT; i++) m_busy[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cyc("R1");

    // R2 / R3: fill with unit stalled, then issue into full pool
    fu_ready = 0;
    for (int k = 0; k < NENT + 1; k++) begin put(k + 1, 1, 0, 1, 0); cyc("R2"); end
    quiet();
    cyc("R3");
    fu_ready = 1;
    for (int k = 0; k < NENT + 1; k++) cyc("R7 R8 drain");

    // R5: issue pending operand while its producer is on the bus
    put(9, 0, 5, 1, 0);
    cdb_valid = 1; cdb_tag = 5; cdb_data = 32'hCAFE0005;
    cyc("R5");
    quiet();
    cyc("R5 dispatch");

    // R4: waiting operand ignores other tags; ready operand not overwritten
    fu_ready = 0;
    put(4, 0, 7, 1, 7);
    cyc("R4 issue");
    quiet(); cdb_valid = 1; cdb_tag = 6; cdb_data = 32'h11;
    cyc("R4 miss");
    cdb_tag = 7; cdb_data = 32'h77;
    cyc("R4 hit");
    quiet(); fu_ready = 1;
    cyc("R4 disp");

    // R7: younger ready first, older ready later wins once ready
    fu_ready = 0;
    put(1, 0, 8, 1, 0); cyc("R7 a");
    put(2, 1, 0, 1, 0); cyc("R7 b");
    quiet(); cdb_valid = 1; cdb_tag = 8; cdb_data = 32'h88; cyc("R7 wake");
    quiet(); fu_ready = 1; cyc("R7 old"); cyc("R7 young");

    // R9: flush with simultaneous issue
    fu_ready = 0;
    put(3, 1, 0, 1, 0); cyc("R9 fill");
    put(5, 1, 0, 1, 0); flush = 1; cyc("R9 flush");
    quiet(); fu_ready = 1; cyc("R9 empty");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      issue_valid = ($urandom % 2) == 0;
      issue_op    = OPW'($urandom);
      issue_dtag  = TAGW'($urandom);
      issue_a_rdy = ($urandom % 3) == 0;
      issue_b_rdy = ($urandom % 3) == 0;
      issue_a_tag = TAGW'($urandom % 6);
      issue_b_tag = TAGW'($urandom % 6);
      issue_a_val = $urandom; issue_b_val = $urandom;
      cdb_valid   = ($urandom % 2) == 0;
      cdb_tag     = TAGW'($urandom % 6);
      cdb_data    = $urandom;
      fu_ready    = ($urandom % 10) < 7;
      flush       = ($urandom % 64) == 0;
      cyc("R4 R6 R7 R8 rand");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule